// File: doc/BRIEF.md
# DMA Multi-Channel Service Scheduler

This block decides which DMA requester receives the next element transfer. The requesters are a set of DMA channels plus one host port, and the host port sits in the same round-robin rotation as an extra channel. A channel element transfer always runs as two phases: a read phase, which moves one element from the source into that channel's holding buffer, and then a write phase, which moves the buffered element to the destination. The host port's access is a single phase that ends on its own done handshake.

A channel can take part only when it is enabled and has a request pending. If it is configured as synchronized, it also needs a latched synchronization event. When the host port holds internal RAM exclusively, every channel that targets internal RAM is passed over in the rotation, so channels with other targets keep moving. A granted channel that targets internal RAM holds its current phase while the processor core has a conflicting request to that memory, or while host-exclusive mode is set. Address generation, memory timing and the bus fabric lie outside this block.

Top module: `dma_svc_sched`

## Requirements
- R1: A channel grant starts with phase code 1 (read). An accepted rd_done moves it to phase code 2 (write). An accepted wr_done ends the transfer: grant goes to zero and the phase returns to code 0 (idle).
- R2: buf_load is high in exactly those cycles where the phase is read and rd_done is accepted. It is combinational on rd_done.
- R3: In an idle cycle the scheduler searches the requester indices upward from the rotation pointer, wrapping round, and grants the first eligible one. The pointer resets to 0. It moves to the granted index plus one (modulo the requester count) only when that requester's transfer completes.
- R4: The host port is requester index NCH (grant bit NCH) and is eligible whenever host_req is high. Its grant shows phase code 3 (host) and ends on host_done.
- R5: A channel is eligible only while both ch_en and ch_req are high.
- R6: Every channel latches ch_sync_evt in a flag register. A channel with ch_sync_mode high is eligible only while that flag is set. The flag clears in the cycle the channel's grant is issued, unless a new event arrives in that same cycle. An event first becomes usable in the cycle after it is sampled.
- R7: While host_excl is high, channels with ch_iram high are not eligible. Other channels and the host port are still granted.
- R8: While the granted channel has ch_iram high and either core_conflict or host_excl is high, rd_done and wr_done are ignored and the phase holds.
- R9: When no requester is eligible in an idle cycle, grant stays zero and the phase stays idle.
- R10: After reset, grant is zero, the phase is idle, buf_load is low and all sync flags are clear.
- R11: A grant appears on the clock edge after the idle cycle in which it was chosen, and it stays stable until its transfer ends. One idle cycle always separates two consecutive transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | NCH | Per-channel enable |
| ch_req | input | NCH | Per-channel pending request |
| ch_sync_mode | input | NCH | Channel waits for a sync event |
| ch_sync_evt | input | NCH | Per-channel sync event pulse |
| ch_iram | input | NCH | Channel targets internal RAM |
| core_conflict | input | 1 | Core has a conflicting internal RAM request |
| host_req | input | 1 | Host port request |
| host_excl | input | 1 | Host holds internal RAM exclusively |
| rd_done | input | 1 | Read phase access completed |
| wr_done | input | 1 | Write phase access completed |
| host_done | input | 1 | Host access completed |
| grant | output | NCH+1 | One-hot grant; bit NCH is the host |
| phase | output | 2 | 0 idle, 1 read, 2 write, 3 host |
| buf_load | output | 1 | Holding buffer load strobe |

## Verification
A wrong rotation pointer shows up at the grant port at the next idle cycle in which two or more requesters compete: the grant goes to the wrong index. A stuck or early-cleared sync flag grants a synchronized channel too soon, or starves it; the grant vector shows this within a cycle of the decision. A phase register that does not respect the stall shows up at once on phase and buf_load, because both are compared against a behavioural model on every cycle while the done inputs toggle at random.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2,
    PH_HOST  = 2'd3
  } phase_t;
endpackage

// File: rtl/dma_sched_elig.sv
module dma_sched_elig #(
  parameter int NCH  = 4,
  localparam int NREQ = NCH + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  ch_en,
  input  logic [NCH-1:0]  ch_req,
  input  logic [NCH-1:0]  ch_sync_mode,
  input  logic [NCH-1:0]  ch_sync_evt,
  input  logic [NCH-1:0]  ch_iram,
  input  logic            host_req,
  input  logic            host_excl,
  input  logic [NCH-1:0]  launch_ch,
  output logic [NREQ-1:0] elig
);
  logic [NCH-1:0] sync_flag;

  // R6: event latch; a new event wins over the launch clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_flag <= '0;
    else        sync_flag <= ch_sync_evt | (sync_flag & ~launch_ch);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sync_ok, excl_block;
    assign sync_ok    = !ch_sync_mode[i] || sync_flag[i];
    assign excl_block = host_excl && ch_iram[i];
    assign elig[i]    = ch_en[i] && ch_req[i] && sync_ok && !excl_block;

    // R6: a synchronized channel never launches without a latched event
    a_r6_sync_launch: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_ch[i] && ch_sync_mode[i]) |-> sync_flag[i]);
    // R6: a launch consumes the flag unless a fresh event arrives
    a_r6_flag_consumed: assert property (@(posedge clk) disable iff (!rst_n)
      (launch_ch[i] && !ch_sync_evt[i]) |=> !sync_flag[i]);
  end
  assign elig[NCH] = host_req;
endmodule

// File: rtl/dma_sched_ctl.sv
module dma_sched_ctl
  import dma_sched_pkg::*;
#(
  parameter int NCH  = 4,
  localparam int NREQ = NCH + 1,
  localparam int PW   = $clog2(NREQ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREQ-1:0] elig,
  input  logic [NCH-1:0]  ch_iram,
  input  logic            core_conflict,
  input  logic            host_excl,
  input  logic            rd_done,
  input  logic            wr_done,
  input  logic            host_done,
  output logic [NREQ-1:0] grant,
  output logic [1:0]      phase_o,
  output logic            buf_load,
  output logic [NREQ-1:0] launch
);
  phase_t          st;
  logic [PW-1:0]   gidx, ptr;
  logic [PW:0]     pick;
  logic            pick_ok, stall_w, xfer_end, iram_g;
  logic [PW-1:0]   pick_idx;

  // next index after v, wrapping at the requester count
  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] v);
    if (int'(v) == NREQ - 1) return '0;
    return v + 1'b1;
  endfunction

  // first eligible index at or after base, circular; returns {found, index}
  function automatic logic [PW:0] rr_pick(input logic [NREQ-1:0] e,
                                          input logic [PW-1:0] base);
    logic [PW:0] r;
    int idx;
    r = '0;
    for (int k = NREQ - 1; k >= 0; k--) begin
      idx = int'(base) + k;
      if (idx >= NREQ) idx = idx - NREQ;
      if (e[idx]) r = {1'b1, PW'(idx)};
    end
    return r;
  endfunction

  function automatic logic iram_of(input logic [NCH-1:0] m, input logic [PW-1:0] g);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (int'(g) == i) r = m[i];
    return r;
  endfunction

  assign pick     = rr_pick(elig, ptr);
  assign pick_ok  = pick[PW];
  assign pick_idx = pick[PW-1:0];
  assign launch   = (st == PH_IDLE && pick_ok) ? (NREQ'(1) << pick_idx) : '0;
  assign iram_g   = iram_of(ch_iram, gidx);
  assign stall_w  = (st == PH_READ || st == PH_WRITE) && iram_g &&
                    (core_conflict || host_excl);
  assign buf_load = (st == PH_READ) && rd_done && !stall_w;
  assign xfer_end = (st == PH_WRITE && wr_done && !stall_w) ||
                    (st == PH_HOST && host_done);
  assign phase_o  = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= PH_IDLE;
      gidx  <= '0;
      ptr   <= '0;
      grant <= '0;
    end else begin
      unique case (st)
        PH_IDLE: if (pick_ok) begin
          st    <= (int'(pick_idx) == NCH) ? PH_HOST : PH_READ;
          gidx  <= pick_idx;
          grant <= launch;
        end
        PH_READ:  if (buf_load) st <= PH_WRITE;
        PH_WRITE, PH_HOST: if (xfer_end) begin
          st    <= PH_IDLE;
          grant <= '0;
          ptr   <= wrap_inc(gidx);
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r1_idle_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_IDLE) == (grant == '0));
  a_r2_load_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    buf_load |=> (st == PH_WRITE));
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> $stable(st));
  a_r11_grant_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st != PH_IDLE && !xfer_end) |=> $stable(grant));
  a_r7_excl_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (|(launch[NCH-1:0] & ch_iram)) |-> !host_excl);
  a_r3_ptr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (ptr == wrap_inc($past(gidx))));
endmodule

// File: rtl/dma_svc_sched.sv
module dma_svc_sched #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] ch_req,
  input  logic [NCH-1:0] ch_sync_mode,
  input  logic [NCH-1:0] ch_sync_evt,
  input  logic [NCH-1:0] ch_iram,
  input  logic           core_conflict,
  input  logic           host_req,
  input  logic           host_excl,
  input  logic           rd_done,
  input  logic           wr_done,
  input  logic           host_done,
  output logic [NCH:0]   grant,
  output logic [1:0]     phase,
  output logic           buf_load
);
  logic [NCH:0] elig_w, launch_w;

  dma_sched_elig #(.NCH(NCH)) u_elig (
    .clk, .rst_n, .ch_en, .ch_req, .ch_sync_mode, .ch_sync_evt, .ch_iram,
    .host_req, .host_excl,
    .launch_ch (launch_w[NCH-1:0]),
    .elig      (elig_w)
  );

  dma_sched_ctl #(.NCH(NCH)) u_ctl (
    .clk, .rst_n,
    .elig      (elig_w),
    .ch_iram, .core_conflict, .host_excl, .rd_done, .wr_done, .host_done,
    .grant, .phase_o (phase), .buf_load,
    .launch    (launch_w)
  );
endmodule

// File: tb/test_dma_svc_sched.sv
module test_dma_svc_sched;
  localparam int NCH = 4;
  localparam int NR  = NCH + 1;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ch_en = 0, ch_req = 0, ch_sync_mode = 0, ch_sync_evt = 0, ch_iram = 0;
  logic core_conflict = 0, host_req = 0, host_excl = 0;
  logic rd_done = 0, wr_done = 0, host_done = 0;
  logic [NCH:0] grant;
  logic [1:0] phase;
  logic buf_load;

  int total = 0, bad = 0;
  bit finished = 0;
  bit rnd_on = 1;
  string cur_req = "R10";

  // behavioural model state
  int m_st = 0, m_g = -1, m_ptr = 0;
  bit m_flag [NCH];

  always #4 clk = ~clk;

  dma_svc_sched #(.NCH(NCH)) i_dma_svc_sched (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_elig(input int i);
    if (i == NCH) return host_req;
    if (!(ch_en[i] && ch_req[i])) return 0;
    if (ch_sync_mode[i] && !m_flag[i]) return 0;
    if (host_excl && ch_iram[i]) return 0;
    return 1;
  endfunction

  task automatic step();
    int n_st, n_g, n_ptr, pick;
    bit stall, exp_bl;
    bit n_flag [NCH];
    if (rnd_on) begin
      rd_done   = 1'($urandom_range(0, 1));
      wr_done   = 1'($urandom_range(0, 1));
      host_done = 1'($urandom_range(0, 1));
    end
    #1;
    stall  = (m_st == 1 || m_st == 2) && m_g < NCH && ch_iram[m_g] && (core_conflict || host_excl);
    exp_bl = (m_st == 1) && rd_done && !stall;
    check(cur_req, "grant", int'(grant), (m_g >= 0) ? (1 << m_g) : 0);
    check(cur_req, "phase", int'(phase), m_st);
    check(cur_req, "buf_load", int'(buf_load), int'(exp_bl));
    n_st = m_st; n_g = m_g; n_ptr = m_ptr; pick = -1;
    for (int i = 0; i < NCH; i++) n_flag[i] = ch_sync_evt[i] | m_flag[i];
    case (m_st)
      0: begin
        for (int k = 0; k < NR && pick < 0; k++)
          if (m_elig((m_ptr + k) % NR)) pick = (m_ptr + k) % NR;
        if (pick >= 0) begin
          n_g = pick;
          n_st = (pick == NCH) ? 3 : 1;
          if (pick < NCH && !ch_sync_evt[pick]) n_flag[pick] = 0;
        end
      end
      1: if (exp_bl) n_st = 2;
      2: if (wr_done && !stall) begin n_st = 0; n_ptr = (m_g + 1) % NR; n_g = -1; end
      3: if (host_done) begin n_st = 0; n_ptr = (m_g + 1) % NR; n_g = -1; end
      default: ;
    endcase
    @(posedge clk); #2;
    m_st = n_st; m_g = n_g; m_ptr = n_ptr;
    for (int i = 0; i < NCH; i++) m_flag[i] = n_flag[i];
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog R11 actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) m_flag[i] = 0;
    // R10: reset state, even with requests present
    ch_en = '1; ch_req = '1; host_req = 1;
    repeat (3) @(negedge clk);
    check("R10", "grant", int'(grant), 0);
    check("R10", "phase", int'(phase), 0);
    check("R10", "buf_load", int'(buf_load), 0);
    ch_req = 0; host_req = 0;
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    cur_req = "R10"; run(3);
    // R1 / R2: single channel, read then write
    cur_req = "R1"; ch_en = 4'b0001; ch_req = 4'b0001; run(30);
    cur_req = "R2"; ch_en = 4'b0100; ch_req = 4'b0100; run(30);
    // R3: all channels compete
    cur_req = "R3"; ch_en = '1; ch_req = '1; run(80);
    // R4: host joins the rotation
    cur_req = "R4"; host_req = 1; run(60);
    // R5: requests without enable
    cur_req = "R5"; host_req = 0; ch_en = 4'b1010; ch_req = '1; run(40);
    // R6: synchronized channel needs an event
    cur_req = "R6"; ch_en = 4'b0011; ch_req = 4'b0011; ch_sync_mode = 4'b0010;
    for (int r = 0; r < 8; r++) begin
      run(6); ch_sync_evt = 4'b0010; step(); ch_sync_evt = 0;
    end
    ch_sync_mode = 4'b0011; run(10);
    ch_sync_evt = 4'b0001; step(); ch_sync_evt = 0; run(12);
    ch_sync_mode = 0;
    // R7: exclusive host skips internal-RAM channels
    cur_req = "R7"; ch_en = '1; ch_req = '1; ch_iram = 4'b0101; host_excl = 1; host_req = 1; run(60);
    host_excl = 0; host_req = 0;
    // R8: core conflict stalls the granted internal-RAM channel
    cur_req = "R8"; ch_iram = 4'b0001; ch_en = 4'b0011; ch_req = 4'b0011;
    for (int r = 0; r < 20; r++) begin
      core_conflict = 1'($urandom_range(0, 1)); step();
    end
    core_conflict = 1; run(10); core_conflict = 0; run(10);
    // R9: nothing eligible
    cur_req = "R9"; ch_req = 0; run(12);
    // R11: grant timing with fixed handshakes
    cur_req = "R11"; rnd_on = 0; rd_done = 1; wr_done = 1; host_done = 1;
    ch_en = '1; ch_req = 4'b1001; host_req = 1; run(25);
    rnd_on = 1;
    // mixed random traffic
    cur_req = "R3";
    for (int r = 0; r < 2500; r++) begin
      if (r % 7 == 0) begin
        ch_en = 4'($urandom); ch_req = 4'($urandom); ch_iram = 4'($urandom);
        ch_sync_mode = 4'($urandom); host_req = 1'($urandom);
        host_excl = ($urandom_range(0, 3) == 0); core_conflict = ($urandom_range(0, 3) == 0);
      end
      ch_sync_evt = 4'($urandom) & 4'($urandom);
      step();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule